// File: doc/BRIEF.md
# 4:2:2 Video Byte-Stream Demultiplexer

This block takes an 8-bit multiplexed 4:2:2 luma/chroma byte stream that arrives on a clock running at twice the pixel rate, together with a vertical sync reference, a horizontal sync reference, an active-video qualifier and an optional per-byte valid qualifier. It rebuilds each four-byte group into one parallel output word: a blue-difference sample, a red-difference sample and two luma samples. The first luma sample shares its picture position with the chroma pair. Each word comes with a one-cycle valid strobe.

The stream carries no embedded timing codes. Byte alignment therefore comes only from the active-video qualifier: every blanking interval returns the byte phase to the blue-difference slot. The block also reports the parity of each field, taken where the vertical reference falls. It counts the bytes accepted in each active line and reports that count when the line ends. A group cut short by blanking is dropped and flagged.

Top module: `ycc_stream_demux`

## Requirements
- R1: Accepted bytes are taken in the repeating order blue-difference, luma, red-difference, luma. Accepted bytes 0, 1, 2 and 3 of a group appear on `pair_cb`, `pair_y0`, `pair_cr` and `pair_y1` respectively.
- R2: Whenever `vactive` is sampled low, the byte phase returns to slot 0. The first accepted byte after blanking is always taken as blue-difference.
- R3: A byte is accepted only on a rising clock edge where `vactive` is high and either `dvalid` is high or `dvalid_en` is low. Any other byte is ignored: it changes no output data and does not advance the byte phase.
- R4: `pair_valid` is high for exactly the one cycle that follows the clock edge sampling the fourth accepted byte of a group. The output data holds its value until the next group completes.
- R5: If `vactive` is sampled low while one to three bytes of a group are held, those bytes are discarded and `group_err` is high for the following cycle. The next group starts fresh at slot 0.
- R6: `pair_sol` is high together with `pair_valid` for the first group completed after reset or after any cycle where `vactive` was sampled low. It is low for every other group.
- R7: On a clock edge where `vref` is sampled low after being sampled high on the previous edge, `field_odd` takes the value of `href` sampled at that edge (1 = odd field, 0 = even field). `field_stb` is high for the following cycle.
- R8: On the first edge where `vactive` is sampled low after being high, `line_bytes` takes the number of bytes accepted during that active period, limited to `MAX_LINE_BYTES`, and `line_done` is high for the following cycle.
- R9: While `rst_n` is sampled low, every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_byte | input | DATA_W | Multiplexed chroma/luma byte |
| vref | input | 1 | Vertical sync reference |
| href | input | 1 | Horizontal sync reference |
| vactive | input | 1 | Active-video qualifier |
| dvalid | input | 1 | Per-byte data-valid qualifier |
| dvalid_en | input | 1 | 1 = `dvalid` gates acceptance, 0 = `dvalid` ignored |
| pair_valid | output | 1 | One-cycle strobe for a completed group |
| pair_cb | output | DATA_W | Blue-difference sample of the group |
| pair_y0 | output | DATA_W | Luma sample sharing its position with the chroma pair |
| pair_cr | output | DATA_W | Red-difference sample of the group |
| pair_y1 | output | DATA_W | Second luma sample |
| pair_sol | output | 1 | First group of an active line |
| group_err | output | 1 | One-cycle pulse, partial group dropped |
| field_odd | output | 1 | Parity of the current field |
| field_stb | output | 1 | One-cycle pulse, field parity updated |
| line_done | output | 1 | One-cycle pulse, line byte count updated |
| line_bytes | output | $clog2(MAX_LINE_BYTES+1) | Bytes accepted in the last active line |

## Verification
The bench builds the block with `DATA_W` = 8 and `MAX_LINE_BYTES` = 40. Random lines of up to 24 bytes therefore stay below the limit, while a directed 60-byte line drives the counter into its limit, a case a 1440-byte limit would keep out of reach of a short run. Lines of random length, many of them not a multiple of four, cause dropped partial groups. Random `dvalid` holes and per-line changes of `dvalid_en` test whether rejected bytes really leave the phase alone. Random toggling of `vref` and `href` produces both odd and even fields.

// File: rtl/ycc_demux_pkg.sv
// Shared definitions for the 4:2:2 byte-stream demultiplexer.
// Assumes a fixed four-byte group: Cb, Y, Cr, Y.
package ycc_demux_pkg;

    localparam int GROUP_BYTES = 4;
    localparam int PHASE_W     = $clog2(GROUP_BYTES);

    typedef enum logic [PHASE_W-1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } ycc_phase_e;

endpackage

// File: rtl/ycc_qualify.sv
// Input qualifier: forms the per-byte accept term and detects the falling
// edges of the active-video and vertical references.
// Assumes all inputs are already synchronous to clk.
module ycc_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic vactive,
    input  logic dvalid,
    input  logic dvalid_en,
    input  logic vref,
    output logic accept,
    output logic act_fall,
    output logic ref_fall
);

    logic vact_q;
    logic vref_q;

    // Keep the previous samples of the two references.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vact_q <= 1'b0;
            vref_q <= 1'b0;
        end else begin
            vact_q <= vactive;
            vref_q <= vref;
        end
    end

    // Accept term and falling-edge detection.
    always_comb begin
        accept   = vactive & (dvalid | ~dvalid_en);
        act_fall = vact_q & ~vactive;
        ref_fall = vref_q & ~vref;
    end

endmodule

// File: rtl/ycc_group_asm.sv
// Group assembler: tracks the byte phase, holds the first three bytes of a
// group and issues the full group on the fourth accepted byte.
// Assumes accept is only high while vactive is high.
module ycc_group_asm
    import ycc_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              accept,
    input  logic              vactive,
    output logic              pair_valid,
    output logic [DATA_W-1:0] pair_cb,
    output logic [DATA_W-1:0] pair_y0,
    output logic [DATA_W-1:0] pair_cr,
    output logic [DATA_W-1:0] pair_y1,
    output logic              pair_sol,
    output logic              group_err
);

    localparam int HOLD_SLOTS = GROUP_BYTES - 1;

    ycc_phase_e        phase_q;
    logic              sol_pend_q;
    logic [DATA_W-1:0] slot_q [HOLD_SLOTS];

    // Byte phase and line-start tracking; blanking returns to the Cb slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_CB;
            sol_pend_q <= 1'b1;
            group_err  <= 1'b0;
        end else begin
            group_err <= 1'b0;
            if (!vactive) begin
                group_err  <= (phase_q != PH_CB);
                phase_q    <= PH_CB;
                sol_pend_q <= 1'b1;
            end else if (accept) begin
                phase_q <= ycc_phase_e'(phase_q + 1'b1);
                if (phase_q == PH_Y1) begin
                    sol_pend_q <= 1'b0;
                end
            end
        end
    end

    // One holding register per leading byte slot.
    for (genvar i = 0; i < HOLD_SLOTS; i++) begin : g_slot
        // Capture the byte that arrives in this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (accept && (phase_q == ycc_phase_e'(i))) begin
                slot_q[i] <= din;
            end
        end
    end

    // Issue the completed group one cycle after its last luma byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
            pair_sol   <= 1'b0;
            pair_cb    <= '0;
            pair_y0    <= '0;
            pair_cr    <= '0;
            pair_y1    <= '0;
        end else begin
            pair_valid <= 1'b0;
            pair_sol   <= 1'b0;
            if (vactive && accept && (phase_q == PH_Y1)) begin
                pair_valid <= 1'b1;
                pair_sol   <= sol_pend_q;
                pair_cb    <= slot_q[PH_CB];
                pair_y0    <= slot_q[PH_Y0];
                pair_cr    <= slot_q[PH_CR];
                pair_y1    <= din;
            end
        end
    end

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R2
    blank_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vactive |=> !pair_valid);

    // R6
    sol_with_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_sol |-> pair_valid);

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group_err |-> !pair_valid);

endmodule

// File: rtl/ycc_field_track.sv
// Field parity tracker: latches href at each trailing edge of vref.
// Assumes ref_fall marks the edge on which vref is first sampled low.
module ycc_field_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_fall,
    input  logic href,
    output logic field_odd,
    output logic field_stb
);

    // Capture the parity and pulse the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_odd <= 1'b0;
            field_stb <= 1'b0;
        end else begin
            field_stb <= ref_fall;
            if (ref_fall) begin
                field_odd <= href;
            end
        end
    end

    // R7
    field_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_stb |-> (field_odd == $past(href)));

endmodule

// File: rtl/ycc_line_count.sv
// Line byte counter: counts accepted bytes of one active period and reports
// the total, limited to MAX_LINE_BYTES, when the period ends.
// Assumes act_fall is high only on the first blank sample after a line.
module ycc_line_count #(
    parameter int MAX_LINE_BYTES = 1440,
    localparam int CNT_W = $clog2(MAX_LINE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             act_fall,
    output logic             line_done,
    output logic [CNT_W-1:0] line_bytes
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LINE_BYTES);

    logic [CNT_W-1:0] cnt_q;

    // Running count and end-of-line report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            line_bytes <= '0;
            line_done  <= 1'b0;
        end else begin
            line_done <= act_fall;
            if (act_fall) begin
                line_bytes <= cnt_q;
                cnt_q      <= '0;
            end else if (accept && (cnt_q < CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8
    line_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_bytes <= CNT_MAX);

    // R8
    line_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

endmodule

// File: rtl/ycc_stream_demux.sv
// Top level of the 4:2:2 byte-stream demultiplexer. Splits a Cb,Y,Cr,Y byte
// stream into parallel groups, tracks field parity and counts line bytes.
// Assumes inputs are synchronous to clk; no embedded timing codes present.
module ycc_stream_demux #(
    parameter int DATA_W         = 8,
    parameter int MAX_LINE_BYTES = 1440,
    localparam int CNT_W = $clog2(MAX_LINE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_byte,
    input  logic              vref,
    input  logic              href,
    input  logic              vactive,
    input  logic              dvalid,
    input  logic              dvalid_en,
    output logic              pair_valid,
    output logic [DATA_W-1:0] pair_cb,
    output logic [DATA_W-1:0] pair_y0,
    output logic [DATA_W-1:0] pair_cr,
    output logic [DATA_W-1:0] pair_y1,
    output logic              pair_sol,
    output logic              group_err,
    output logic              field_odd,
    output logic              field_stb,
    output logic              line_done,
    output logic [CNT_W-1:0]  line_bytes
);

    logic accept;
    logic act_fall;
    logic ref_fall;

    ycc_qualify u_qualify (
        .clk      (clk),
        .rst_n    (rst_n),
        .vactive  (vactive),
        .dvalid   (dvalid),
        .dvalid_en(dvalid_en),
        .vref     (vref),
        .accept   (accept),
        .act_fall (act_fall),
        .ref_fall (ref_fall)
    );

    ycc_group_asm #(.DATA_W(DATA_W)) u_group (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (pix_byte),
        .accept    (accept),
        .vactive   (vactive),
        .pair_valid(pair_valid),
        .pair_cb   (pair_cb),
        .pair_y0   (pair_y0),
        .pair_cr   (pair_cr),
        .pair_y1   (pair_y1),
        .pair_sol  (pair_sol),
        .group_err (group_err)
    );

    ycc_field_track u_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_fall (ref_fall),
        .href     (href),
        .field_odd(field_odd),
        .field_stb(field_stb)
    );

    ycc_line_count #(.MAX_LINE_BYTES(MAX_LINE_BYTES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .act_fall  (act_fall),
        .line_done (line_done),
        .line_bytes(line_bytes)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pair_valid && !group_err && !line_done && !field_stb));

endmodule

// File: tb/ycc_stream_demux_tb.sv
module ycc_stream_demux_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int MAXB       = 40;
    localparam int CNT_W      = $clog2(MAXB + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] pix_byte = '0;
    logic              vref = 1'b0, href = 1'b0, vactive = 1'b0;
    logic              dvalid = 1'b0, dvalid_en = 1'b0;
    logic              pair_valid, pair_sol, group_err, field_odd, field_stb, line_done;
    logic [DATA_W-1:0] pair_cb, pair_y0, pair_cr, pair_y1;
    logic [CNT_W-1:0]  line_bytes;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_phase, m_cnt, m_solp;
    bit m_vq, m_rq, m_field;
    int m_buf [4];
    int e_cb, e_y0, e_cr, e_y1, e_lb;
    bit e_valid, e_sol, e_err, e_stb, e_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ycc_stream_demux #(.DATA_W(DATA_W), .MAX_LINE_BYTES(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_byte(pix_byte), .vref(vref), .href(href),
        .vactive(vactive), .dvalid(dvalid), .dvalid_en(dvalid_en),
        .pair_valid(pair_valid), .pair_cb(pair_cb), .pair_y0(pair_y0),
        .pair_cr(pair_cr), .pair_y1(pair_y1), .pair_sol(pair_sol),
        .group_err(group_err), .field_odd(field_odd), .field_stb(field_stb),
        .line_done(line_done), .line_bytes(line_bytes)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_cnt = 0; m_solp = 1; m_vq = 0; m_rq = 0; m_field = 0;
        e_cb = 0; e_y0 = 0; e_cr = 0; e_y1 = 0; e_lb = 0;
    endtask

    // expected outputs from the requirements, given the sampled inputs
    task automatic model_step(input int d, input bit va, input bit dv, input bit dve,
                              input bit vr, input bit hr);
        e_valid = 0; e_sol = 0; e_err = 0; e_stb = 0; e_done = 0;
        if (!va) begin                       // R2 R5
            e_err = (m_phase != 0);
            m_phase = 0;
            m_solp = 1;
        end else if (dv || !dve) begin       // R3
            m_buf[m_phase] = d;
            if (m_phase == 3) begin          // R1 R4 R6
                e_valid = 1; e_sol = m_solp[0]; m_solp = 0;
                e_cb = m_buf[0]; e_y0 = m_buf[1]; e_cr = m_buf[2]; e_y1 = m_buf[3];
            end
            m_phase = (m_phase + 1) % 4;
            if (m_cnt < MAXB) m_cnt++;
        end
        if (m_vq && !va) begin               // R8
            e_done = 1; e_lb = m_cnt; m_cnt = 0;
        end
        m_vq = va;
        if (m_rq && !vr) begin               // R7
            e_stb = 1; m_field = hr;
        end
        m_rq = vr;
    endtask

    task automatic compare();
        chk(pair_valid == e_valid, "R3 R4 pair_valid", int'(pair_valid), int'(e_valid));
        if (e_valid) begin
            chk(pair_cb == e_cb[7:0], "R1 R2 pair_cb", int'(pair_cb), e_cb);
            chk(pair_y0 == e_y0[7:0], "R1 pair_y0", int'(pair_y0), e_y0);
            chk(pair_cr == e_cr[7:0], "R1 pair_cr", int'(pair_cr), e_cr);
            chk(pair_y1 == e_y1[7:0], "R1 pair_y1", int'(pair_y1), e_y1);
            chk(pair_sol == e_sol, "R6 pair_sol", int'(pair_sol), int'(e_sol));
        end
        chk(group_err == e_err, "R5 group_err", int'(group_err), int'(e_err));
        chk(field_stb == e_stb, "R7 field_stb", int'(field_stb), int'(e_stb));
        chk(field_odd == m_field, "R7 field_odd", int'(field_odd), int'(m_field));
        chk(line_done == e_done, "R8 line_done", int'(line_done), int'(e_done));
        if (e_done)
            chk(line_bytes == CNT_W'(e_lb), "R8 line_bytes", int'(line_bytes), e_lb);
    endtask

    task automatic cyc(input int d, input bit va, input bit dv, input bit dve,
                       input bit vr, input bit hr);
        @(negedge clk);
        pix_byte = d[7:0]; vactive = va; dvalid = dv; dvalid_en = dve; vref = vr; href = hr;
        @(posedge clk);
        #1;
        model_step(d, va, dv, dve, vr, hr);
        compare();
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) cyc($urandom % 256, 1'b0, 1'b0, 1'b1, vref, href);
    endtask

    task automatic line(input int len, input bit dve, input int hole_pct);
        for (int i = 0; i < len; i++)
            cyc($urandom % 256, 1'b1, ($urandom % 100) >= hole_pct, dve, vref, href);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pix_byte = 8'hA5; vactive = 1'b1; dvalid = 1'b1; vref = 1'b1; href = 1'b1;
        end
        @(negedge clk);
        // R9: reset state
        chk(pair_valid == 0 && group_err == 0 && field_stb == 0 && line_done == 0,
            "R9 strobes", int'({pair_valid, group_err, field_stb, line_done}), 0);
        chk(field_odd == 0 && line_bytes == 0 && pair_cb == 0 && pair_y1 == 0,
            "R9 data", int'(line_bytes), 0);
        vactive = 1'b0; vref = 1'b0; href = 1'b0;
        rst_n = 1'b1;
        blank(2);

        // R3: dvalid ignored when disabled, two groups from 8 bytes
        for (int i = 0; i < 8; i++) cyc(16 + i, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        blank(2);
        // R3: every byte rejected, no pair and zero count
        line(12, 1'b1, 100);
        blank(2);
        // R5: 6 bytes, one group then a dropped partial group
        line(6, 1'b0, 0);
        blank(2);
        // R8: long line saturates the count
        line(60, 1'b0, 0);
        blank(1);
        chk(line_bytes == CNT_W'(MAXB), "R8 saturation", int'(line_bytes), MAXB);
        // R7: odd then even field
        cyc(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(field_odd == 1'b1, "R7 odd field", int'(field_odd), 1);
        cyc(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(field_odd == 1'b0, "R7 even field", int'(field_odd), 0);

        // random lines
        for (int ln = 0; ln < 300; ln++) begin
            int len;
            bit dve;
            len = $urandom_range(0, 24);
            dve = $urandom % 2;
            for (int i = 0; i < len; i++) begin
                bit vr;
                vr = (($urandom % 16) == 0) ? ~vref : vref;
                cyc($urandom % 256, 1'b1, ($urandom % 5) != 0, dve, vr, $urandom % 2);
            end
            for (int i = 0; i < int'($urandom_range(1, 4)); i++) begin
                bit vr;
                vr = (($urandom % 4) == 0) ? ~vref : vref;
                cyc($urandom % 256, 1'b0, $urandom % 2, dve, vr, $urandom % 2);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule